// File: doc/BRIEF.md
# CEC Line Receiver with Acknowledge

This block listens to a single open-drain control line and turns its pulse-width coded traffic into byte frames. A tick enable, nominally one per microsecond, drives every timing measurement, so all thresholds are parameters counted in ticks. The line passes through a two-flop synchronizer before any decision is made.

A frame opens with a long low start pulse followed by a short high phase. Both phases are checked against windows. Each bit slot that follows begins with a falling edge and is sampled a fixed number of ticks later. Ten slots make one byte: eight data bits sent MSB first, an end-of-message flag, and an acknowledge slot. The low nibble of the first byte names the destination. When that destination is directed rather than the all-ones broadcast value, and its bit is set in the address mask, the block pulls the line low through the acknowledge slot.

Bit periods that are too short cause the block to hold the line low for one and a half bit periods as an error signal. Bit periods that are too long make it abandon the frame. A finished frame is announced with a one-cycle valid pulse together with its byte count and buffer contents. The buffer is cleared every time the block goes back to idle.

Top module: `cec_line_rx`

## Requirements
- R1: After reset drive_low_o, frame_valid_o and low_drive_err_o are 0, and frame_len_o and frame_data_o are all zero.
- R2: A start pulse whose low phase lasts fewer than START_LOW_MIN ticks is rejected. Slot pulses that follow it are too short to count as a start, so no frame is reported and the line is never driven.
- R3: A start pulse whose high phase lasts more than START_HIGH_MAX ticks after the rising edge is rejected, with no frame reported and no drive.
- R4: Each bit is sampled SAMPLE_AT ticks after its falling edge, and a low line reads as 0. Slots 0 to 7 fill the current byte MSB first. Byte i appears at frame_data_o[8*i+7:8*i].
- R5: Slot 8 holds the end-of-message flag, and it sets the length to the byte index plus one. After the acknowledge slot of a byte whose flag is 1, once the line is high again, frame_valid_o pulses for exactly one cycle with frame_len_o and frame_data_o valid.
- R6: When the destination (byte 0, bits 3:0) is not 15 and its bit is set in addr_mask_i, drive_low_o is high for exactly ACK_LOW ticks, starting at the detected falling edge of each acknowledge slot.
- R7: Destination 15 is broadcast. It is never acknowledged, even with addr_mask_i[15] set, and the frame is still reported.
- R8: A directed frame whose mask bit is clear is not acknowledged, and the frame is still reported.
- R9: If the line stays high more than BIT_MAX ticks after a bit began, the frame is abandoned without a report.
- R10: A falling edge that arrives fewer than BIT_MIN ticks after the bit began causes a one-cycle low_drive_err_o pulse. drive_low_o is then high for exactly LOW_DRIVE ticks, and no frame is reported.
- R11: Bytes beyond NBYTES are not stored, but their timing and acknowledge are still handled. frame_len_o saturates at NBYTES.
- R12: After a report the block waits BIT_MIN ticks from the start of the last acknowledge slot and then returns to idle. On that return, frame_len_o and frame_data_o are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing tick enable (one per microsecond by default) |
| line_i | input | 1 | Raw level of the shared line |
| addr_mask_i | input | 16 | One bit per logical address to acknowledge |
| drive_low_o | output | 1 | Pull the line low (acknowledge or error) |
| low_drive_err_o | output | 1 | One-cycle pulse when a short bit period is detected |
| frame_valid_o | output | 1 | One-cycle pulse when a frame completes |
| frame_len_o | output | $clog2(NBYTES+1) | Received byte count |
| frame_data_o | output | 8*NBYTES | Received bytes, byte 0 in the low bits |

## Verification
The assertions assume that tick_i and line_i are well behaved. The line only goes high again after the block releases its own drive, and addr_mask_i holds steady for the length of a frame. The stimulus keeps to this by driving the line as a wired-AND of the bench level with the block's drive, changing levels only on falling clock edges, and setting the mask between frames. Timing parameters are scaled down by ten. Every pulse the bench sends sits well clear of the window limits, except where a test deliberately breaks one limit.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_LOW,
    ST_START_HIGH,
    ST_SAMPLE,
    ST_HIGH,
    ST_ACK_LOW,
    ST_ACK_END,
    ST_FINISH,
    ST_LOW_DRIVE
  } rx_state_e;
endpackage

// File: rtl/cec_rx_sync.sv
module cec_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (tick_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;

  assert_timer_saturates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX);
endmodule

// File: rtl/cec_rx_buffer.sv
module cec_rx_buffer #(
  parameter int NBYTES = 16,
  localparam int SEL_W = $clog2(NBYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [SEL_W-1:0]    byte_i,
  input  logic [2:0]          bit_i,
  input  logic                val_i,
  output logic [8*NBYTES-1:0] data_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                  byte_q <= '0;
      else if (clr_i)                               byte_q <= '0;
      else if (wr_i && byte_i == SEL_W'(g))         byte_q[3'd7 - bit_i] <= val_i;
    assign data_o[8*g +: 8] = byte_q;
  end

  assert_clear_empties_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> data_o == '0);
endmodule

// File: rtl/cec_line_rx.sv
module cec_line_rx
  import cec_rx_pkg::*;
#(
  parameter int NBYTES         = 16,
  parameter int START_LOW_MIN  = 3500,
  parameter int START_HIGH_MAX = 1200,
  parameter int SAMPLE_AT      = 850,
  parameter int BIT_MAX        = 2750,
  parameter int BIT_MIN        = 2050,
  parameter int ACK_LOW        = 1500,
  parameter int LOW_DRIVE      = 3600,
  parameter int SYNC_STAGES    = 2,
  localparam int LEN_W         = $clog2(NBYTES+1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                line_i,
  input  logic [15:0]         addr_mask_i,
  output logic                drive_low_o,
  output logic                low_drive_err_o,
  output logic                frame_valid_o,
  output logic [LEN_W-1:0]    frame_len_o,
  output logic [8*NBYTES-1:0] frame_data_o
);
  localparam int SEL_W = $clog2(NBYTES);
  localparam int CNT_W = $clog2(START_LOW_MIN + START_HIGH_MAX + SAMPLE_AT + BIT_MAX
                                + BIT_MIN + ACK_LOW + LOW_DRIVE) + 1;
  localparam logic [CNT_W-1:0] C_START_LOW_MIN  = CNT_W'(START_LOW_MIN);
  localparam logic [CNT_W-1:0] C_START_HIGH_MAX = CNT_W'(START_HIGH_MAX);
  localparam logic [CNT_W-1:0] C_SAMPLE_M1      = CNT_W'(SAMPLE_AT - 1);
  localparam logic [CNT_W-1:0] C_BIT_MAX        = CNT_W'(BIT_MAX);
  localparam logic [CNT_W-1:0] C_BIT_MIN        = CNT_W'(BIT_MIN);
  localparam logic [CNT_W-1:0] C_BIT_MIN_M1     = CNT_W'(BIT_MIN - 1);
  localparam logic [CNT_W-1:0] C_ACK_M1         = CNT_W'(ACK_LOW - 1);
  localparam logic [CNT_W-1:0] C_DRIVE_M1       = CNT_W'(LOW_DRIVE - 1);
  localparam logic [LEN_W-1:0] C_NBYTES         = LEN_W'(NBYTES);

  rx_state_e        st_q, st_d;
  logic             line_s, line_p, fall, rise;
  logic [CNT_W-1:0] cnt;
  logic             tmr_clr, buf_clr, buf_wr;
  logic [3:0]       slot_q, slot_d;
  logic [LEN_W-1:0] byte_q, byte_d, len_q, len_d;
  logic             eom_q, eom_d, valid_d, err_d;
  logic [3:0]       dest;
  logic             ack_me;

  cec_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s));

  cec_rx_timer #(.W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(tmr_clr), .cnt_o(cnt));

  cec_rx_buffer #(.NBYTES(NBYTES)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(buf_clr), .wr_i(buf_wr),
    .byte_i(byte_q[SEL_W-1:0]), .bit_i(slot_q[2:0]), .val_i(line_s),
    .data_o(frame_data_o));

  assign fall   = line_p && !line_s;
  assign rise   = !line_p && line_s;
  assign dest   = frame_data_o[3:0];
  assign ack_me = (dest != 4'hF) && addr_mask_i[dest];

  always_comb begin
    st_d    = st_q;
    tmr_clr = 1'b0;
    buf_clr = 1'b0;
    buf_wr  = 1'b0;
    slot_d  = slot_q;
    byte_d  = byte_q;
    len_d   = len_q;
    eom_d   = eom_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (fall) begin
        st_d = ST_START_LOW; tmr_clr = 1'b1;
      end
      ST_START_LOW: if (rise) begin
        tmr_clr = 1'b1;
        st_d    = (cnt < C_START_LOW_MIN) ? ST_IDLE : ST_START_HIGH;
      end
      ST_START_HIGH: begin
        if (fall) begin
          st_d = ST_SAMPLE; tmr_clr = 1'b1; slot_d = '0; byte_d = '0; eom_d = 1'b0;
        end else if (line_s && cnt > C_START_HIGH_MAX) st_d = ST_IDLE;
      end
      ST_SAMPLE: if (tick_i && cnt >= C_SAMPLE_M1) begin
        st_d   = ST_HIGH;
        slot_d = slot_q + 4'd1;
        if (slot_q < 4'd8) buf_wr = (byte_q < C_NBYTES);
        else if (slot_q == 4'd8) begin
          eom_d = line_s;
          len_d = (byte_q < C_NBYTES) ? byte_q + 1'b1 : C_NBYTES;
        end
      end
      ST_HIGH: begin
        if (fall) begin
          tmr_clr = 1'b1;
          if (cnt < C_BIT_MIN) begin
            st_d = ST_LOW_DRIVE; err_d = 1'b1;
          end else if (slot_q != 4'd9) st_d = ST_SAMPLE;
          else                         st_d = ack_me ? ST_ACK_LOW : ST_ACK_END;
        end else if (line_s && cnt > C_BIT_MAX) st_d = ST_IDLE;
      end
      ST_ACK_LOW: if (tick_i && cnt >= C_ACK_M1) st_d = ST_ACK_END;
      ST_ACK_END: if (line_s) begin
        if (eom_q) begin
          st_d = ST_FINISH; valid_d = 1'b1;
        end else begin
          st_d   = ST_HIGH;
          slot_d = '0;
          if (byte_q < C_NBYTES) byte_d = byte_q + 1'b1;
        end
      end
      ST_FINISH:    if (tick_i && cnt >= C_BIT_MIN_M1) st_d = ST_IDLE;
      ST_LOW_DRIVE: if (tick_i && cnt >= C_DRIVE_M1)   st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
    if (st_d == ST_IDLE && st_q != ST_IDLE) begin
      buf_clr = 1'b1; len_d = '0; slot_d = '0; byte_d = '0; eom_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q            <= ST_IDLE;
      line_p          <= 1'b1;
      slot_q          <= '0;
      byte_q          <= '0;
      len_q           <= '0;
      eom_q           <= 1'b0;
      frame_valid_o   <= 1'b0;
      low_drive_err_o <= 1'b0;
    end else begin
      st_q            <= st_d;
      line_p          <= line_s;
      slot_q          <= slot_d;
      byte_q          <= byte_d;
      len_q           <= len_d;
      eom_q           <= eom_d;
      frame_valid_o   <= valid_d;
      low_drive_err_o <= err_d;
    end

  assign drive_low_o = (st_q == ST_ACK_LOW) || (st_q == ST_LOW_DRIVE);
  assign frame_len_o = len_q;

  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  assert_valid_has_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (frame_len_o != '0 && frame_len_o <= C_NBYTES));
  assert_valid_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> $past(st_q == ST_ACK_END));
  assert_err_drives_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_drive_err_o |-> drive_low_o);
  assert_no_bcast_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK_LOW) |-> frame_data_o[3:0] != 4'hF);
endmodule

// File: tb/cec_line_rx_bench.sv
module cec_line_rx_bench;
  localparam int NB   = 4;
  localparam int ACKT = 150;
  localparam int LDT  = 360;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bench_line = 1'b1;
  logic              line;
  logic [15:0]       addr_mask = '0;
  logic              drive_low, err, valid;
  logic [2:0]        len;
  logic [8*NB-1:0]   data;

  int tests = 0, fails = 0;
  int drv_cnt = 0, err_cnt = 0, vcnt = 0;
  logic [2:0]      cap_len;
  logic [8*NB-1:0] cap_data;
  logic [7:0]      fb [5];

  always #4 clk = ~clk;
  assign line = bench_line & ~drive_low;

  cec_line_rx #(
    .NBYTES(NB), .START_LOW_MIN(350), .START_HIGH_MAX(120), .SAMPLE_AT(85),
    .BIT_MAX(275), .BIT_MIN(205), .ACK_LOW(ACKT), .LOW_DRIVE(LDT)
  ) u_cec_line_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .line_i(line),
    .addr_mask_i(addr_mask), .drive_low_o(drive_low), .low_drive_err_o(err),
    .frame_valid_o(valid), .frame_len_o(len), .frame_data_o(data));

  always @(negedge clk) begin
    if (drive_low) drv_cnt++;
    if (err) err_cnt++;
    if (valid) begin vcnt++; cap_len = len; cap_data = data; end
  end

  // {hdr, data, nbytes, mask, acked bytes}
  localparam logic [47:0] VEC [6] = '{
    {8'h14, 8'hA5, 8'd2, 16'h0010, 8'd2},
    {8'h14, 8'h5A, 8'd2, 16'h0020, 8'd0},
    {8'h0F, 8'h3C, 8'd2, 16'hFFFF, 8'd0},
    {8'h40, 8'h00, 8'd1, 16'h0001, 8'd1},
    {8'h3E, 8'hFF, 8'd2, 16'h4000, 8'd2},
    {8'hE0, 8'h81, 8'd2, 16'h0000, 8'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    drv_cnt = 0; err_cnt = 0; vcnt = 0; cap_len = '0; cap_data = '0;
  endtask

  task automatic send_start(input int lo, input int hi);
    bench_line = 1'b0; wait_n(lo);
    bench_line = 1'b1; wait_n(hi);
  endtask

  task automatic send_bit(input bit b);
    int lo;
    lo = b ? 60 : 150;
    bench_line = 1'b0; wait_n(lo);
    bench_line = 1'b1; wait_n(240 - lo);
  endtask

  task automatic send_frame(input int n, input int lo, input int hi);
    send_start(lo, hi);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) send_bit(fb[k][b]);
      send_bit(k == n - 1);
      send_bit(1'b1);
    end
    bench_line = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    // R1 reset state
    check(drive_low == 0 && valid == 0 && err == 0, "R1 outputs", {drive_low, valid, err}, 0);
    check(len == 0 && data == 0, "R1 buffer", int'(data), 0);
    rst_n = 1'b1;
    wait_n(50);

    for (int i = 0; i < 6; i++) begin
      logic [47:0] v;
      string tag;
      int n, acks;
      v = VEC[i];
      fb[0] = v[47:40]; fb[1] = v[39:32];
      n = int'(v[31:24]); addr_mask = v[23:8]; acks = int'(v[7:0]);
      tag = (v[43:40] == 4'hF) ? "R7" : (acks != 0) ? "R6" : "R8";
      clear_counts();
      send_frame(n, 370, 80);
      wait_n(300);
      check(vcnt == 1, "R5 one report", vcnt, 1);
      check(int'(cap_len) == n, "R5 length", int'(cap_len), n);
      check(cap_data[7:0] == fb[0], "R4 byte0", int'(cap_data[7:0]), int'(fb[0]));
      if (n == 2) check(cap_data[15:8] == fb[1], "R4 byte1", int'(cap_data[15:8]), int'(fb[1]));
      check(drv_cnt == acks * ACKT, tag, drv_cnt, acks * ACKT);
      check(data == 0 && len == 0, "R12 cleared", int'(data), 0);
    end

    // R2 short start low
    fb[0] = 8'h10; addr_mask = 16'hFFFF; clear_counts();
    send_frame(1, 200, 250); wait_n(300);
    check(vcnt == 0 && drv_cnt == 0, "R2 reject", vcnt + drv_cnt, 0);

    // R3 start high too long
    clear_counts();
    send_frame(1, 370, 200); wait_n(300);
    check(vcnt == 0 && drv_cnt == 0, "R3 reject", vcnt + drv_cnt, 0);

    // R9 line stays high past the bit window
    clear_counts();
    send_start(370, 80); send_bit(1); send_bit(0); send_bit(1);
    wait_n(400);
    check(vcnt == 0 && drv_cnt == 0, "R9 abandon", vcnt + drv_cnt, 0);
    check(data == 0 && len == 0, "R9 cleared", int'(data), 0);

    // R10 short bit period
    clear_counts();
    send_start(370, 80); send_bit(1);
    bench_line = 1'b0; wait_n(60); bench_line = 1'b1; wait_n(40);
    bench_line = 1'b0; wait_n(20); bench_line = 1'b1; wait_n(500);
    check(err_cnt == 1, "R10 err pulse", err_cnt, 1);
    check(drv_cnt == LDT, "R10 drive length", drv_cnt, LDT);
    check(vcnt == 0, "R10 no report", vcnt, 0);

    // R11 frame longer than the buffer
    fb[0] = 8'h21; fb[1] = 8'h11; fb[2] = 8'h22; fb[3] = 8'h33; fb[4] = 8'h44;
    addr_mask = 16'h0002; clear_counts();
    send_frame(5, 370, 80); wait_n(300);
    check(vcnt == 1, "R11 report", vcnt, 1);
    check(int'(cap_len) == NB, "R11 length cap", int'(cap_len), NB);
    check(cap_data == 32'h33221121, "R11 stored bytes", int'(cap_data), 32'h33221121);
    check(drv_cnt == 5 * ACKT, "R11 ack all bytes", drv_cnt, 5 * ACKT);

    // R12 frame after an abandoned one still decodes
    fb[0] = 8'h12; fb[1] = 8'hC3; addr_mask = 16'h0004; clear_counts();
    send_frame(2, 370, 80); wait_n(300);
    check(vcnt == 1 && cap_data[15:0] == 16'hC312, "R12 recover", int'(cap_data[15:0]), 16'hC312);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule